// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Access Controller

This block is a synthesizable behavioural model of a synchronous static RAM with registered inputs and a registered read path. Every control input is sampled on the rising clock edge. A state machine decides at each edge whether the device starts an access, carries on with a burst, finishes a pending write, or drops to deselected. Two address strobes can open an access. The processor strobe `pstb_n` only counts while `cs_a_n` is low, and it always leaves the write decision to the following edge. The controller strobe `cstb_n` takes its write controls on the same edge as the address. A 2-bit wrap-around burst counter walks the low address bits in either linear or interleaved order.

The word is split into byte lanes of `LANE_W` bits. A global write writes every lane. A byte write writes only the selected lanes. The data pads appear as separate input and output buses with a drive-enable output (`dq_drv`), which a pad ring combines into one three-state bus. The output enable acts on `dq_drv` without passing through a register.

The states are `S_IDLE` (deselected), `S_PEND` (address taken by the processor strobe, waiting for the second edge), `S_READ` (read data flowing through the output register) and `S_WRITE` (last edge wrote the array). On each edge the controller does one of the following:

- **Deselect:** any strobe with an inactive chip select goes to `S_IDLE`.
- **Processor start:** a valid processor strobe goes to `S_PEND`.
- **Controller start:** a valid controller strobe goes to `S_WRITE` when write controls are active, otherwise to `S_READ`.
- **No strobe:** an active state goes to `S_WRITE` when write controls are active, otherwise to `S_READ`. `S_IDLE` stays in `S_IDLE`.

Top module: `sync_sram_ctl`

## Requirements
- R1: An access starts at a rising edge when a strobe is valid and `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. The processor strobe `pstb_n`=0 is valid only with `cs_a_n`=0; `cstb_n`=0 is always valid. When both strobes are valid, the processor strobe wins, so the write controls of that edge are ignored.
- R2: With `cs_a_n`=1, `pstb_n`=0 has no effect. A deselected device stays deselected, and an active read keeps returning the same word.
- R3: A read captures the address at the strobe edge. The word appears on `dq_out` with `dq_drv`=1 after the next edge, provided `out_en_n`=0. Consecutive reads can be issued on every edge with no idle cycle.
- R4: On the first cycle after a strobe selects the device out of `S_IDLE`, `dq_drv` stays 0 even when `out_en_n`=0.
- R5: A strobe at an edge where any chip select is inactive puts the device in `S_IDLE`, and `dq_drv` is 0 right after that edge.
- R6: For a processor-strobe access, `wr_all_n`, `wr_byte_n`, `lane_sel_n` and `step_n` are ignored at the strobe edge. At the second edge, active write controls write `dq_in` to the captured address; otherwise the access reads it.
- R7: For a controller-strobe access with active write controls, `dq_in` is written to `addr` on the strobe edge itself.
- R8: `wr_all_n`=0 writes every lane, whatever `wr_byte_n` and `lane_sel_n` are.
- R9: With `wr_all_n`=1, lane g (bits g*9+8..g*9, lane A = bit 0 of `lane_sel_n`, lane B = bit 1) is written only if `wr_byte_n`=0 and `lane_sel_n[g]`=0. With both write enables high the edge is a read.
- R10: `step_n`=0 at a read edge advances the low two address bits after that read. From start s, the i-th word of a burst is at offset (s+i) mod 4 when `burst_ilv`=0 and at s xor i when `burst_ilv`=1. The upper bits never change, and the sequence wraps after four words.
- R11: A write continuation edge with `step_n`=0 writes the next address of the burst sequence.
- R12: `out_en_n`=1 forces `dq_drv` low without waiting for a clock. `dq_out` keeps its registered word.
- R13: During and after reset the device is in `S_IDLE` with `dq_drv`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| cs_a_n | input | 1 | Chip select A, active low, also gates `pstb_n` |
| cs_b | input | 1 | Chip select B, active high |
| cs_c_n | input | 1 | Chip select C, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES | Per-lane byte select, active low |
| burst_ilv | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Output enable, active low, acts without a clock |
| dq_in | input | LANES*LANE_W | Write data from the pads |
| dq_out | output | LANES*LANE_W | Registered read data |
| dq_drv | output | 1 | Pad drive enable for `dq_out` |

## Verification
The assertions check the following on every cycle:

- a valid processor strobe always leads to `S_PEND`;
- a deselecting strobe always clears the output drive;
- reselection from `S_IDLE` holds the drive off for one cycle;
- a controller-strobe write never drives the bus;
- a read continuation always turns the drive on;
- output enable high always gates the drive.

Only the bench scenarios can show that the right data lands in the right place. These cover:

- which lanes a write touches;
- that a processor-strobe write lands at the captured address on the second edge and not the first;
- the exact burst address order in both modes, including the wrap;
- that an ignored processor strobe leaves the stored words untouched.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PEND  = 2'd1,
        S_READ  = 2'd2,
        S_WRITE = 2'd3
    } ctl_state_e;

    // low two address bits of burst word c starting at s
    function automatic logic [1:0] burst_lo(input logic [1:0] s,
                                            input logic [1:0] c,
                                            input logic       ilv);
        return ilv ? (s ^ c) : (s + c);
    endfunction

endpackage

// File: rtl/sram_strobe_dec.sv
`timescale 1ns/1ps
module sram_strobe_dec #(
    parameter int LANES = 2
) (
    input  logic             pstb_n,
    input  logic             cstb_n,
    input  logic             cs_a_n,
    input  logic             cs_b,
    input  logic             cs_c_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic             proc_go,
    output logic             any_go,
    output logic             chip_sel,
    output logic             wr_req,
    output logic [LANES-1:0] lane_we
);

    assign proc_go  = !pstb_n && !cs_a_n;
    assign any_go   = proc_go || !cstb_n;
    assign chip_sel = !cs_a_n && cs_b && !cs_c_n;
    assign wr_req   = !wr_all_n || !wr_byte_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = !wr_all_n || (!wr_byte_n && !lane_sel_n[g]);
    end

endmodule

// File: rtl/sram_burst_ctr.sv
`timescale 1ns/1ps
module sram_burst_ctr
    import sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  logic          ilv,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] cur_nxt
);

    localparam int HW = AW - 2;

    logic [HW-1:0] base_q;
    logic [1:0]    start_q;
    logic [1:0]    cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            base_q  <= load_addr[AW-1:2];
            start_q <= load_addr[1:0];
            cnt_q   <= '0;
        end else if (step) begin
            cnt_q   <= cnt_q + 2'd1;
        end
    end

    assign cur     = {base_q, burst_lo(start_q, cnt_q, ilv)};
    assign cur_nxt = {base_q, burst_lo(start_q, cnt_q + 2'd1, ilv)};

endmodule

// File: rtl/sram_array.sv
`timescale 1ns/1ps
module sram_array #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [LANES-1:0] we_lane,
    input  logic [AW-1:0]    waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [LANES*LANE_W-1:0] q
);

    localparam int DEPTH = 1 << AW;
    localparam int DW    = LANES * LANE_W;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int g = 0; g < LANES; g++) begin
                if (we_lane[g]) begin
                    mem[waddr][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (re) begin
            q <= mem[raddr];
        end
    end

endmodule

// File: rtl/sync_sram_ctl.sv
`timescale 1ns/1ps
module sync_sram_ctl
    import sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    pstb_n,
    input  logic                    cstb_n,
    input  logic                    step_n,
    input  logic                    cs_a_n,
    input  logic                    cs_b,
    input  logic                    cs_c_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    burst_ilv,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drv
);

    logic             proc_go, any_go, chip_sel, wr_req;
    logic [LANES-1:0] lane_we;
    logic [AW-1:0]    cur, cur_nxt, wa;
    logic             ld, step, rd, wr, drv_nxt, out_ok;
    ctl_state_e       state, nxt;

    sram_strobe_dec #(.LANES(LANES)) u_dec (
        .pstb_n     (pstb_n),
        .cstb_n     (cstb_n),
        .cs_a_n     (cs_a_n),
        .cs_b       (cs_b),
        .cs_c_n     (cs_c_n),
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .lane_sel_n (lane_sel_n),
        .proc_go    (proc_go),
        .any_go     (any_go),
        .chip_sel   (chip_sel),
        .wr_req     (wr_req),
        .lane_we    (lane_we)
    );

    sram_burst_ctr #(.AW(AW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_addr (addr),
        .step      (step),
        .ilv       (burst_ilv),
        .cur       (cur),
        .cur_nxt   (cur_nxt)
    );

    sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr),
        .we_lane (lane_we),
        .waddr   (wa),
        .wdata   (dq_in),
        .re      (rd),
        .raddr   (cur),
        .q       (dq_out)
    );

    // next-state and per-edge action decode
    always_comb begin
        nxt     = state;
        ld      = 1'b0;
        step    = 1'b0;
        rd      = 1'b0;
        wr      = 1'b0;
        wa      = cur;
        drv_nxt = 1'b0;
        if (any_go && !chip_sel) begin
            nxt = S_IDLE;
        end else if (any_go) begin
            ld      = 1'b1;
            rd      = (state == S_READ) || (state == S_PEND);
            drv_nxt = rd;
            if (proc_go) begin
                nxt = S_PEND;
            end else if (wr_req) begin
                wr      = 1'b1;
                wa      = addr;
                drv_nxt = 1'b0;
                nxt     = S_WRITE;
            end else begin
                nxt = S_READ;
            end
        end else begin
            unique case (state)
                S_IDLE: nxt = S_IDLE;
                S_PEND: begin
                    if (wr_req) begin
                        wr  = 1'b1;
                        nxt = S_WRITE;
                    end else begin
                        rd      = 1'b1;
                        drv_nxt = 1'b1;
                        step    = !step_n;
                        nxt     = S_READ;
                    end
                end
                S_READ, S_WRITE: begin
                    step = !step_n;
                    if (wr_req) begin
                        wr  = 1'b1;
                        wa  = step_n ? cur : cur_nxt;
                        nxt = S_WRITE;
                    end else begin
                        rd      = 1'b1;
                        drv_nxt = 1'b1;
                        nxt     = S_READ;
                    end
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_ok <= 1'b0;
        else        out_ok <= drv_nxt;
    end

    assign dq_drv = out_ok && !out_en_n;

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk
    import sram_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pstb_n,
    input logic       cstb_n,
    input logic       cs_a_n,
    input logic       cs_b,
    input logic       cs_c_n,
    input logic       wr_all_n,
    input logic       wr_byte_n,
    input logic       out_en_n,
    input logic       dq_drv,
    input ctl_state_e state,
    input logic       out_ok
);

    logic pgo, anygo, sel;
    assign pgo   = !pstb_n && !cs_a_n;
    assign anygo = pgo || !cstb_n;
    assign sel   = !cs_a_n && cs_b && !cs_c_n;

    p_proc_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pgo && sel) |=> (state == S_PEND));

    p_first_z_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && anygo && sel) |=> !out_ok);

    p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (anygo && !sel) |=> (state == S_IDLE && !out_ok));

    p_proc_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cs_a_n && cstb_n) |=> (state == S_IDLE));

    p_ctrl_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgo && !cstb_n && sel && (!wr_all_n || !wr_byte_n))
        |=> (state == S_WRITE && !out_ok));

    p_read_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ && !anygo && wr_all_n && wr_byte_n) |=> out_ok);

    p_oe_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dq_drv);

endmodule

bind sync_sram_ctl sram_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pstb_n    (pstb_n),
    .cstb_n    (cstb_n),
    .cs_a_n    (cs_a_n),
    .cs_b      (cs_b),
    .cs_c_n    (cs_c_n),
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .out_en_n  (out_en_n),
    .dq_drv    (dq_drv),
    .state     (state),
    .out_ok    (out_ok)
);

// File: tb/sync_sram_ctl_tb.sv
`timescale 1ns/1ps
module sync_sram_ctl_tb;

    localparam int AW = 6, DEPTH = 64, DW = 18;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr;
    logic          pstb_n, cstb_n, step_n, cs_a_n, cs_b, cs_c_n;
    logic          wr_all_n, wr_byte_n, burst_ilv, out_en_n;
    logic [1:0]    lane_sel_n;
    logic [DW-1:0] dq_in, dq_out;
    logic          dq_drv;

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] exp_mem [DEPTH];

    always #2.5 clk = ~clk;

    sync_sram_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .pstb_n(pstb_n), .cstb_n(cstb_n),
        .step_n(step_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
        .burst_ilv(burst_ilv), .out_en_n(out_en_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_drv(dq_drv)
    );

    function automatic logic [DW-1:0] pat(int a, int salt);
        return DW'((a * 1311 + salt * 7919 + 77) ^ (a << 9));
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        pstb_n = 1'b1; cstb_n = 1'b1; step_n = 1'b1;
        wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_sel_n = 2'b11;
    endtask

    task automatic deselect();
        quiet();
        cstb_n = 1'b0; cs_b = 1'b0;
        tick();
        cs_b = 1'b1; cstb_n = 1'b1;
    endtask

    task automatic read_range(int lo, int n, string tag);
        deselect();
        out_en_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            quiet();
            addr = AW'(lo + i);
            cstb_n = 1'b0;
            tick();
            if (i == 0) check("R4 first cycle drive", DW'(dq_drv), '0);
            else begin
                check(tag, dq_out, exp_mem[lo + i - 1]);
                check("R3 drive", DW'(dq_drv), DW'(1));
            end
        end
        quiet();
        tick();
        check(tag, dq_out, exp_mem[lo + n - 1]);
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [1:0]    m;
        logic [DW-1:0] d;
        addr = '0; out_en_n = 1'b0; cs_a_n = 1'b0; cs_b = 1'b1; cs_c_n = 1'b0;
        burst_ilv = 1'b0; dq_in = '0;
        quiet();
        repeat (3) tick();
        check("R13 drive in reset", DW'(dq_drv), '0);
        rst_n = 1'b1;
        tick();
        check("R13 drive after reset", DW'(dq_drv), '0);
        out_en_n = 1'b1;

        // R7 R8: controller-strobe global writes to every word
        for (int a = 0; a < DEPTH; a++) begin
            quiet();
            addr = AW'(a); cstb_n = 1'b0; wr_all_n = 1'b0;
            dq_in = pat(a, 0); exp_mem[a] = pat(a, 0);
            tick();
        end
        quiet();
        tick();
        read_range(0, DEPTH, "R3 R7 sweep");

        // R3 / R12 on a live read of word 5
        quiet(); addr = 6'd5; cstb_n = 1'b0; tick();
        quiet(); tick();
        check("R3 data", dq_out, exp_mem[5]);
        check("R3 drive", DW'(dq_drv), DW'(1));
        out_en_n = 1'b1; #1;
        check("R12 drive off", DW'(dq_drv), '0);
        check("R12 data kept", dq_out, exp_mem[5]);
        out_en_n = 1'b0; #1;
        check("R12 drive on", DW'(dq_drv), DW'(1));

        // R2 while active: strobe with cs_a_n high must not restart
        pstb_n = 1'b0; cs_a_n = 1'b1; addr = 6'd9; tick();
        check("R2 active ignore", dq_out, exp_mem[5]);
        cs_a_n = 1'b0; pstb_n = 1'b1; tick();
        check("R2 active ignore", dq_out, exp_mem[5]);

        // R5 deselect by cs_c_n
        cstb_n = 1'b0; cs_c_n = 1'b1; tick();
        check("R5 deselect drive", DW'(dq_drv), '0);
        cs_c_n = 1'b0; quiet(); tick();
        check("R5 stays idle", DW'(dq_drv), '0);

        // R2 while idle
        pstb_n = 1'b0; cs_a_n = 1'b1; addr = 6'd9; tick();
        quiet(); cs_a_n = 1'b0; tick();
        check("R2 idle ignore", DW'(dq_drv), '0);
        tick();
        check("R2 idle ignore", DW'(dq_drv), '0);

        // R6: write controls at the processor strobe edge are ignored
        deselect();
        out_en_n = 1'b1;
        pstb_n = 1'b0; addr = 6'd12; wr_all_n = 1'b0; wr_byte_n = 1'b0;
        lane_sel_n = 2'b00; dq_in = ~exp_mem[12];
        tick();
        quiet(); out_en_n = 1'b0; tick();
        check("R6 first edge write ignored", dq_out, exp_mem[12]);
        check("R1 processor read drive", DW'(dq_drv), DW'(1));

        // R6: processor-strobe write completes on the second edge
        out_en_n = 1'b1; quiet();
        pstb_n = 1'b0; addr = 6'd13; tick();
        pstb_n = 1'b1; wr_all_n = 1'b0; dq_in = pat(13, 3); exp_mem[13] = pat(13, 3);
        tick();
        quiet(); tick();

        // R1: processor strobe wins over controller strobe
        pstb_n = 1'b0; cstb_n = 1'b0; wr_all_n = 1'b0; addr = 6'd14; dq_in = ~exp_mem[14];
        tick();
        quiet(); out_en_n = 1'b0; tick();
        check("R1 precedence", dq_out, exp_mem[14]);
        out_en_n = 1'b1;

        // R8 R9: all write-enable and lane-select combinations
        for (int k = 0; k < 16; k++) begin
            quiet();
            addr = AW'(20 + k); cstb_n = 1'b0;
            wr_all_n = k[3]; wr_byte_n = k[2]; lane_sel_n = k[1:0];
            d = pat(20 + k, 4); dq_in = d;
            if (!k[3])      m = 2'b11;
            else if (!k[2]) m = ~k[1:0];
            else            m = 2'b00;
            if (m[0]) exp_mem[20 + k][8:0]  = d[8:0];
            if (m[1]) exp_mem[20 + k][17:9] = d[17:9];
            tick();
        end
        quiet(); tick();
        read_range(20, 16, "R8 R9 lanes");

        // R10: burst orders from every start offset
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                deselect();
                burst_ilv = md[0]; out_en_n = 1'b0;
                addr = AW'(32 + s); cstb_n = 1'b0; tick();
                quiet(); step_n = 1'b0;
                for (int i = 0; i < 5; i++) begin
                    tick();
                    check("R10 burst", dq_out,
                          exp_mem[32 + (md == 1 ? ((s ^ i) & 3) : ((s + i) & 3))]);
                end
            end
        end

        // R11: interleaved burst write from offset 2
        deselect();
        burst_ilv = 1'b1; out_en_n = 1'b1;
        addr = 6'd42; cstb_n = 1'b0; wr_all_n = 1'b0;
        dq_in = pat(42, 5); exp_mem[42] = pat(42, 5);
        tick();
        cstb_n = 1'b1; step_n = 1'b0;
        for (int i = 1; i < 4; i++) begin
            dq_in = pat(40 + (2 ^ i), 5);
            exp_mem[40 + (2 ^ i)] = pat(40 + (2 ^ i), 5);
            tick();
        end
        quiet();
        burst_ilv = 1'b0;
        read_range(40, 4, "R11 burst write");

        read_range(0, DEPTH, "R3 R6 final sweep");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule